// File: doc/BRIEF.md
# Audio Serial Master Clock Generator

This block produces the bit clock and the left/right frame clock of an audio serial port when the device is the clock master and its PLL is bypassed. The external master clock is the block's only clock, and both outputs are made from it by counting. A two-bit ratio select gives the number of master-clock cycles in one sample period (256, 512 or 1024). A one-bit select sets how many bit clocks fit in one sample period (32 or 64). The block also gives the serial data shifters a one-cycle frame-start pulse each time the frame clock enters the left-channel level. In this design the left-channel level is low.

Any change to a select that matters, and any entry into master-with-PLL-bypassed mode, restarts every counter in the same cycle. Both clocks then begin again from low, so no short pulse can appear. Outside that mode the block is idle and its outputs stay low. This is a clock generator with no data path, so every pin is a plain control or clock-level signal with no handshake.

Top module: `audclk_master_gen`

## Requirements
- R1: The block runs only while `pll_en` is 0 and `is_master` is 1. After any edge of `mclk` at which this does not hold, `bclk_o`, `fclk_o` and `frame_start_o` are all 0 until the mode is entered again.
- R2: `rate_sel[1:0]` sets the sample period in `mclk` cycles as follows: 2'b00 gives 256, 2'b01 gives 1024, and both 2'b10 and 2'b11 give 512.
- R3: `bclk_o` has a 50% duty cycle. Its period is the sample period divided by 32 when `bclk_sel` is 0, and divided by 64 when `bclk_sel` is 1. This gives 4, 8, 16 or 32 `mclk` cycles.
- R4: `fclk_o` has a period of exactly one sample period. It toggles after every 16 bit-clock periods (`bclk_sel`=0) or every 32 bit-clock periods (`bclk_sel`=1), and it changes only on the edge at which `bclk_o` falls.
- R5: `frame_start_o` is high for exactly one `mclk` cycle. It is high in the cycle in which `fclk_o` has just gone from 1 to 0 (the left-channel level).
- R6: A restart happens at an `mclk` edge while the mode is active if either of these holds: `rate_sel[1:0]` or `bclk_sel` differs from its value at the previous edge, or the mode was inactive at the previous edge. At that edge all outputs go to 0. Call that edge t0 and let H be half the bit-clock period. `bclk_o` then first rises at edge t0+H and first falls at t0+2H. `fclk_o` first rises at t0 plus half a sample period. `fclk_o` first falls, and `frame_start_o` first goes high, at t0 plus one sample period.
- R7: While `rst_n` is 0 all outputs are 0. The first active edge after `rst_n` rises is treated as a mode entry (R6).
- R8: Bits of `rate_sel` above bit 1 are ignored. Changing them neither restarts the counters nor alters the output timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | External master clock; the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | SEL_W (4) | Master-clock ratio select; only bits [1:0] are decoded |
| bclk_sel | input | 1 | Bit-clock multiple: 0 = 32 per sample, 1 = 64 per sample |
| pll_en | input | 1 | PLL enable flag; the block runs only while it is 0 |
| is_master | input | 1 | Master flag; the block runs only while it is 1 |
| bclk_o | output | 1 | Serial bit clock |
| fclk_o | output | 1 | Frame (left/right) clock; low = left channel |
| frame_start_o | output | 1 | One-cycle pulse when the frame clock goes to the left-channel level |

## Verification
Every output is a register, so the effect of a select change or a mode change is visible one `mclk` edge after the edge that samples it. The bench records the edge number t0 of each restart. It expects bit-clock transitions at t0 plus multiples of H, frame-clock transitions at t0 plus multiples of half a sample period, and the frame-start pulse in the cycle after t0 plus each whole sample period. The driver loads these stamped events into a queue. The monitor samples on the falling edge of `mclk`, tags each output transition with the number of the last rising edge, and compares it with the head of the queue. Any edge that arrives early, late, out of order or unannounced therefore fails at the exact cycle it occurs.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  // Decoded width of the ratio select.
  localparam int RATE_W = 2;
  // Largest half bit-clock period is 16 master cycles; the counter holds half-1.
  localparam int HALF_MAX = 16;
  localparam int DIV_W = $clog2(HALF_MAX);
  // Largest number of bit clocks per frame half is 32; counter holds count-1.
  localparam int SLOT_MAX = 32;
  localparam int SLOT_W = $clog2(SLOT_MAX);

  typedef enum logic [RATE_W-1:0] {
    MR_256   = 2'b00,
    MR_1024  = 2'b01,
    MR_512_A = 2'b10,
    MR_512_B = 2'b11
  } mrate_e;

  typedef struct packed {
    mrate_e rate;
    logic   wide;   // 1: 64 bit clocks per sample, 0: 32
  } clkcfg_t;

  // Half of the bit-clock period in master cycles, minus one.
  function automatic logic [DIV_W-1:0] half_m1(clkcfg_t c);
    logic [DIV_W:0] half;
    case (c.rate)
      MR_256:  half = (DIV_W+1)'(HALF_MAX / 4);
      MR_1024: half = (DIV_W+1)'(HALF_MAX);
      default: half = (DIV_W+1)'(HALF_MAX / 2);
    endcase
    if (c.wide) half = half >> 1;
    return DIV_W'(half - 1'b1);
  endfunction

  // Bit clocks in one frame-clock half period, minus one.
  function automatic logic [SLOT_W-1:0] slot_last(logic wide);
    return wide ? SLOT_W'(SLOT_MAX - 1) : SLOT_W'(SLOT_MAX / 2 - 1);
  endfunction

endpackage

// File: rtl/audclk_mode_ctl.sv
module audclk_mode_ctl
  import audclk_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             wide_sel,
  input  logic             pll_en,
  input  logic             is_master,
  output clkcfg_t          cfg_q,
  output logic             clr
);

  clkcfg_t cfg_in;
  logic    mode_ok;
  logic    act_q;

  always_comb begin
    cfg_in.rate = mrate_e'(rate_sel[RATE_W-1:0]);
    cfg_in.wide = wide_sel;
  end

  // Bits above the decoded field carry no meaning in this mode.
  generate
    if (SEL_W > RATE_W) begin : g_hi_sel
      logic hi_sel_unused;
      assign hi_sel_unused = ^rate_sel[SEL_W-1:RATE_W];
    end
  endgenerate

  assign mode_ok = !pll_en && is_master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      act_q <= 1'b0;
    end else begin
      cfg_q <= cfg_in;
      act_q <= mode_ok;
    end
  end

  // Hold everything cleared while idle; pulse a restart on entry or on a change.
  assign clr = !mode_ok || !act_q || (cfg_in != cfg_q);

endmodule

// File: rtl/audclk_bclk_div.sv
module audclk_bclk_div
  import audclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] half_m1,
  output logic             bclk,
  output logic             fall_now
);

  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap     = (cnt == half_m1);
  assign fall_now = !clr && wrap && bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/audclk_frame_div.sv
module audclk_frame_div
  import audclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fall_now,
  input  logic [SLOT_W-1:0] last,
  output logic              fclk,
  output logic              fstart
);

  logic [SLOT_W-1:0] slot;
  logic              at_end;

  assign at_end = (slot == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= '0;
      fclk   <= 1'b0;
      fstart <= 1'b0;
    end else if (clr) begin
      slot   <= '0;
      fclk   <= 1'b0;
      fstart <= 1'b0;
    end else begin
      // Left channel is the low level: mark the 1 -> 0 move.
      fstart <= fall_now && at_end && fclk;
      if (fall_now) begin
        if (at_end) begin
          slot <= '0;
          fclk <= ~fclk;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/audclk_master_gen.sv
module audclk_master_gen
  import audclk_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             bclk_sel,
  input  logic             pll_en,
  input  logic             is_master,
  output logic             bclk_o,
  output logic             fclk_o,
  output logic             frame_start_o
);

  clkcfg_t cfg_q;
  logic    clr;
  logic    fall_now;

  audclk_mode_ctl #(.SEL_W(SEL_W)) u_mode (
    .clk       (mclk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .wide_sel  (bclk_sel),
    .pll_en    (pll_en),
    .is_master (is_master),
    .cfg_q     (cfg_q),
    .clr       (clr)
  );

  audclk_bclk_div u_bdiv (
    .clk      (mclk),
    .rst_n    (rst_n),
    .clr      (clr),
    .half_m1  (half_m1(cfg_q)),
    .bclk     (bclk_o),
    .fall_now (fall_now)
  );

  audclk_frame_div u_fdiv (
    .clk      (mclk),
    .rst_n    (rst_n),
    .clr      (clr),
    .fall_now (fall_now),
    .last     (slot_last(cfg_q.wide)),
    .fclk     (fclk_o),
    .fstart   (frame_start_o)
  );

endmodule

// File: rtl/audclk_master_gen_chk.sv
module audclk_master_gen_chk (
  input logic       mclk,
  input logic       rst_n,
  input logic [1:0] rate_lo,
  input logic       bclk_sel,
  input logic       pll_en,
  input logic       is_master,
  input logic       bclk_o,
  input logic       fclk_o,
  input logic       frame_start_o
);

  AST_IDLE_QUIET: assert property (@(posedge mclk) disable iff (!rst_n)
    (pll_en || !is_master) |=> (!bclk_o && !fclk_o && !frame_start_o)); // R1

  AST_FCLK_ON_BCLK_LOW: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(fclk_o) |-> !bclk_o); // R4

  AST_FSTART_SINGLE: assert property (@(posedge mclk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o); // R5

  AST_FSTART_ON_FALL: assert property (@(posedge mclk) disable iff (!rst_n)
    frame_start_o |-> (!fclk_o && $past(fclk_o))); // R5

  AST_RESTART_LOW: assert property (@(posedge mclk) disable iff (!rst_n)
    (!pll_en && is_master &&
     ((rate_lo != $past(rate_lo)) || (bclk_sel != $past(bclk_sel))))
    |=> (!bclk_o && !fclk_o && !frame_start_o)); // R6

  AST_ENTRY_LOW: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(!pll_en && is_master) |=> (!bclk_o && !fclk_o && !frame_start_o)); // R6

endmodule

bind audclk_master_gen audclk_master_gen_chk u_chk (
  .mclk          (mclk),
  .rst_n         (rst_n),
  .rate_lo       (rate_sel[1:0]),
  .bclk_sel      (bclk_sel),
  .pll_en        (pll_en),
  .is_master     (is_master),
  .bclk_o        (bclk_o),
  .fclk_o        (fclk_o),
  .frame_start_o (frame_start_o)
);

// File: tb/sim_audclk_master_gen.sv
module sim_audclk_master_gen;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] rate_sel;
  logic       bclk_sel, pll_en, is_master;
  logic       bclk_o, fclk_o, frame_start_o;

  always #10 clk = ~clk;   // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int win_lo = 0, win_hi = -1;
  int exp_q[$];              // each item: cycle*8 + kind
  logic pb = 1'b0, pf = 1'b0, pfs = 1'b0;

  audclk_master_gen u0 (
    .mclk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .bclk_sel(bclk_sel),
    .pll_en(pll_en), .is_master(is_master),
    .bclk_o(bclk_o), .fclk_o(fclk_o), .frame_start_o(frame_start_o)
  );

  // kinds: 0/1 bit clock rise/fall, 2/3 frame clock rise/fall, 4/5 pulse rise/fall
  function automatic string kind_req(int k);
    if (k < 2) return "R3";
    if (k < 4) return "R4";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic note(input int k);
    if (cyc > win_lo && cyc <= win_hi) begin
      if (exp_q.size() == 0)
        check(1'b0, kind_req(k), "unannounced edge (cycle*8+kind)", cyc*8 + k, -1);
      else begin
        int e = exp_q.pop_front();
        check(e == cyc*8 + k, kind_req(k), "edge (cycle*8+kind)", cyc*8 + k, e);
      end
    end
  endtask

  // Monitor: stamps every output transition with the last rising-edge number.
  always @(negedge clk) begin
    if (rst_n) begin
      if (bclk_o !== pb) note(bclk_o ? 0 : 1);
      if (fclk_o !== pf) note(fclk_o ? 2 : 3);
      if (frame_start_o !== pfs) note(frame_start_o ? 4 : 5);
    end
    pb  = bclk_o;
    pf  = fclk_o;
    pfs = frame_start_o;
  end

  function automatic int ratio_of(logic [1:0] r);   // R2 decode
    case (r)
      2'b00:   return 256;
      2'b01:   return 1024;
      default: return 512;
    endcase
  endfunction

  task automatic push_exp(input int t0, input int w, input int ratio, input int half);
    for (int d = 1; d <= w; d++) begin
      int c = t0 + d;
      if (d % half == 0)        exp_q.push_back(c*8 + (((d/half) % 2 == 1) ? 0 : 1));
      if (d % (ratio/2) == 0)   exp_q.push_back(c*8 + (((d/(ratio/2)) % 2 == 1) ? 2 : 3));
      if (d % ratio == 0)       exp_q.push_back(c*8 + 4);
      if (d > 1 && d % ratio == 1) exp_q.push_back(c*8 + 5);
    end
  endtask

  task automatic run_cfg(input bit from_reset, input logic [1:0] rs, input logic bs,
                         input int w, input int flip_at, input string req);
    int t0, ratio, half;
    @(negedge clk);
    exp_q.delete();
    rate_sel[1:0] = rs;
    bclk_sel      = bs;
    pll_en        = 1'b0;
    is_master     = 1'b1;
    if (from_reset) rst_n = 1'b1;
    ratio = ratio_of(rs);
    half  = ratio / (bs ? 128 : 64);
    t0 = cyc + 1;
    win_lo = t0;
    win_hi = t0 + w;
    push_exp(t0, w, ratio, half);
    @(negedge clk);
    check(!bclk_o && !fclk_o && !frame_start_o, "R6", "outputs low at restart edge",
          {bclk_o, fclk_o, frame_start_o}, 0);
    while (cyc <= t0 + w) begin
      if (flip_at > 0 && cyc == t0 + flip_at) rate_sel[3:2] = ~rate_sel[3:2];  // R8
      @(negedge clk);
    end
    check(exp_q.size() == 0, req, "announced edges never seen", exp_q.size(), 0);
  endtask

  task automatic idle_run(input bit use_pll, input int w);
    int t;
    @(negedge clk);
    exp_q.delete();
    if (use_pll) pll_en = 1'b1; else is_master = 1'b0;
    t = cyc + 1;
    win_lo = t;
    win_hi = t + w;
    @(negedge clk);
    check(!bclk_o && !fclk_o && !frame_start_o, "R1", "outputs low after leaving mode",
          {bclk_o, fclk_o, frame_start_o}, 0);
    while (cyc <= t + w) begin
      if (cyc == t + w/2) bclk_sel = ~bclk_sel;
      @(negedge clk);
    end
    check(!bclk_o && !fclk_o && !frame_start_o, "R1", "outputs still low while idle",
          {bclk_o, fclk_o, frame_start_o}, 0);
  endtask

  initial begin
    rst_n = 1'b0; rate_sel = 4'b0000; bclk_sel = 1'b0; pll_en = 1'b0; is_master = 1'b1;
    repeat (5) @(negedge clk);
    check(!bclk_o && !fclk_o && !frame_start_o, "R7", "outputs during reset",
          {bclk_o, fclk_o, frame_start_o}, 0);
    run_cfg(1'b1, 2'b00, 1'b0,  600,   0, "R7");
    run_cfg(1'b0, 2'b01, 1'b1, 2100,   0, "R2");
    run_cfg(1'b0, 2'b10, 1'b0, 1100, 300, "R8");
    run_cfg(1'b0, 2'b11, 1'b1, 1100,   0, "R2");
    run_cfg(1'b0, 2'b01, 1'b0, 2100,   0, "R3");
    run_cfg(1'b0, 2'b00, 1'b1,  600,   0, "R4");
    idle_run(1'b1, 300);
    run_cfg(1'b0, 2'b00, 1'b0,  600,   0, "R6");
    idle_run(1'b0, 300);
    run_cfg(1'b0, 2'b00, 1'b0,  600,   0, "R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule